// File: doc/BRIEF.md
# Frame Buffer Address Translator

This block sits between a display fetch engine and the memory system. The fetch engine sees its frame buffer as one linear byte range starting at zero. The lowest 80KB of that range lives in on-chip SRAM. Everything above it spills into external memory, one 4KB page at a time. The overflow pages may sit anywhere in external memory, provided each starts on a 4KB boundary, so the whole buffer still reads as one unbroken range to the fetch engine.

Each request carries a linear byte address and an access size: byte, half-word or word. The translator registers its answer, so the result arrives one cycle after the request is accepted. The answer is one of three things:

- an on-chip physical address;
- an external physical address, built from a page table entry plus the untouched 12-bit page offset;
- an error with address zero.

An error is returned when the request is misaligned, names a reserved size, falls past the last table page, or hits an invalid table entry.

Software fills the 32-entry table through a simple write port. Each entry holds a 20-bit external page base and a valid bit.

Top module: `fb_xlate`

## Requirements
- R1: A request with linear address below 81920 (0x14000) and legal alignment returns physical address SRAM_BASE (default 0xB000_0000) plus the linear address, with ext=0 and err=0.
- R2: A request at or above 0x14000 uses table index ((addr - 0x14000) >> 12). If that entry is valid, the response is {entry base[19:0], addr[11:0]} with ext=1 and err=0.
- R3: A request that maps to a table entry whose valid bit is 0 returns err=1, ext=0 and address 0.
- R4: A request whose table index is 32 or more (addr >= 0x34000) returns err=1, ext=0 and address 0.
- R5: The size encoding is 0 = byte, 1 = half-word, 2 = word and 3 = reserved. Each of the following returns err=1, ext=0 and address 0, whatever the address:
  - a half-word with addr[0]=1;
  - a word with addr[1:0] not equal to 0;
  - size 3.
- R6: A request accepted on a clock edge (valid and ready both high) has its response valid right after that edge.
- R7: While rsp_valid_o=1 and rsp_ready_i=0, req_ready_o is 0 and the response (address, ext, err) holds steady.
- R8: A table write (pt_we_i=1) loads base and valid into entry pt_idx_i at the clock edge. A request accepted on the same edge still sees the entry's old contents. Later requests see the new contents.
- R9: After reset, rsp_valid_o=0, req_ready_o=1 and every table entry is invalid.
- R10: With rsp_ready_i held at 1, req_ready_o stays 1, so one request is accepted and answered every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 32 | Linear frame buffer byte address |
| req_size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_addr_o | output | 32 | Physical address, 0 on error |
| rsp_ext_o | output | 1 | Address is in external memory |
| rsp_err_o | output | 1 | Translation failed |
| pt_we_i | input | 1 | Page table write strobe |
| pt_idx_i | input | 5 | Page table entry to write |
| pt_base_i | input | 20 | External page base, upper 20 address bits |
| pt_valid_i | input | 1 | Valid bit to store |

## Verification
Two functions can fall on the same clock edge: a table write and a lookup of the very entry being written. The bench provokes this by writing a previously invalid entry in the same cycle that a request to that page is accepted. It expects an error, since the old contents must win. It then sends a second request to the same page and expects the newly written base.

The bench also overlaps acceptance of a new request with a stalled response. It holds rsp_ready_i low and keeps a request pending, then checks two things: the held response does not change, and the pending request is taken exactly when the stall clears.

// File: rtl/fb_xlate_pkg.sv
package fb_xlate_pkg;
  parameter int PHYS_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [PHYS_W-1:0] addr;
    logic              ext;
    logic              err;
  } xlate_rsp_t;
endpackage

// File: rtl/fb_page_table.sv
module fb_page_table #(
  parameter int NUM_PAGES = 32,
  parameter int BASE_W    = 20,
  parameter int IDX_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [BASE_W-1:0] wbase_i,
  input  logic              wvalid_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [BASE_W-1:0] rbase_o,
  output logic              rvalid_o
);
  logic [BASE_W-1:0] base_q  [NUM_PAGES];
  logic              valid_q [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        base_q[g]  <= wbase_i;
        valid_q[g] <= wvalid_i;
      end
    end
  end

  // read path sees pre-write contents on a same-cycle write
  assign rbase_o  = base_q[ridx_i];
  assign rvalid_o = valid_q[ridx_i];
endmodule

// File: rtl/fb_addr_decode.sv
module fb_addr_decode
  import fb_xlate_pkg::*;
#(
  parameter int          LIN_W        = 32,
  parameter int          ONCHIP_BYTES = 81920,
  parameter int          PAGE_BITS    = 12,
  parameter int          NUM_PAGES    = 32,
  parameter int          IDX_W        = $clog2(NUM_PAGES),
  parameter logic [31:0] SRAM_BASE    = 32'hB000_0000
) (
  input  logic [LIN_W-1:0]     addr_i,
  input  acc_size_e            size_i,
  output logic                 on_chip_o,
  output logic                 in_range_o,
  output logic                 misalign_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [PAGE_BITS-1:0] offset_o,
  output logic [PHYS_W-1:0]    sram_addr_o
);
  localparam logic [LIN_W-1:0] ONCHIP_L = LIN_W'(ONCHIP_BYTES);
  localparam logic [LIN_W-1:0] PAGES_L  = LIN_W'(NUM_PAGES);

  logic [LIN_W-1:0] page_full;

  always_comb begin
    page_full   = (addr_i - ONCHIP_L) >> PAGE_BITS;
    on_chip_o   = addr_i < ONCHIP_L;
    in_range_o  = page_full < PAGES_L;
    idx_o       = page_full[IDX_W-1:0];
    offset_o    = addr_i[PAGE_BITS-1:0];
    sram_addr_o = PHYS_W'(SRAM_BASE) + PHYS_W'(addr_i);
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_i[0];
      SZ_WORD: misalign_o = |addr_i[1:0];
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fb_rsp_stage.sv
module fb_rsp_stage
  import fb_xlate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  xlate_rsp_t in_data_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output xlate_rsp_t out_data_o
);
  logic       valid_q;
  xlate_rsp_t data_q;

  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/fb_xlate.sv
module fb_xlate
  import fb_xlate_pkg::*;
#(
  parameter int          LIN_W        = 32,
  parameter int          ONCHIP_BYTES = 81920,
  parameter int          PAGE_BITS    = 12,
  parameter int          NUM_PAGES    = 32,
  parameter logic [31:0] SRAM_BASE    = 32'hB000_0000,
  parameter int          IDX_W        = $clog2(NUM_PAGES),
  parameter int          BASE_W       = PHYS_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LIN_W-1:0]  req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PHYS_W-1:0] rsp_addr_o,
  output logic              rsp_ext_o,
  output logic              rsp_err_o,
  input  logic              pt_we_i,
  input  logic [IDX_W-1:0]  pt_idx_i,
  input  logic [BASE_W-1:0] pt_base_i,
  input  logic              pt_valid_i
);
  logic                 on_chip, in_range, misalign;
  logic [IDX_W-1:0]     idx;
  logic [PAGE_BITS-1:0] offset;
  logic [PHYS_W-1:0]    sram_addr;
  logic [BASE_W-1:0]    ent_base;
  logic                 ent_valid;
  xlate_rsp_t           nxt, cur;

  fb_addr_decode #(
    .LIN_W(LIN_W), .ONCHIP_BYTES(ONCHIP_BYTES), .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .SRAM_BASE(SRAM_BASE)
  ) u_dec (
    .addr_i      (req_addr_i),
    .size_i      (acc_size_e'(req_size_i)),
    .on_chip_o   (on_chip),
    .in_range_o  (in_range),
    .misalign_o  (misalign),
    .idx_o       (idx),
    .offset_o    (offset),
    .sram_addr_o (sram_addr)
  );

  fb_page_table #(
    .NUM_PAGES(NUM_PAGES), .BASE_W(BASE_W), .IDX_W(IDX_W)
  ) u_pt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pt_we_i),
    .widx_i   (pt_idx_i),
    .wbase_i  (pt_base_i),
    .wvalid_i (pt_valid_i),
    .ridx_i   (idx),
    .rbase_o  (ent_base),
    .rvalid_o (ent_valid)
  );

  always_comb begin
    nxt = '0;
    if (misalign) begin
      nxt.err = 1'b1;
    end else if (on_chip) begin
      nxt.addr = sram_addr;
    end else if (!in_range || !ent_valid) begin
      nxt.err = 1'b1;
    end else begin
      nxt.addr = {ent_base, offset};
      nxt.ext  = 1'b1;
    end
  end

  fb_rsp_stage u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (nxt),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (cur)
  );

  assign rsp_addr_o = cur.addr;
  assign rsp_ext_o  = cur.ext;
  assign rsp_err_o  = cur.err;
endmodule

// File: rtl/fb_xlate_chk.sv
module fb_xlate_chk #(
  parameter int          LIN_W        = 32,
  parameter int          PHYS_W       = 32,
  parameter int          ONCHIP_BYTES = 81920,
  parameter int          PAGE_BITS    = 12,
  parameter int          NUM_PAGES    = 32,
  parameter logic [31:0] SRAM_BASE    = 32'hB000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LIN_W-1:0]  req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [PHYS_W-1:0] rsp_addr_o,
  input logic              rsp_ext_o,
  input logic              rsp_err_o
);
  localparam logic [LIN_W-1:0] TOP_L =
    LIN_W'(ONCHIP_BYTES) + (LIN_W'(NUM_PAGES) << PAGE_BITS);
  localparam logic [PHYS_W-1:0] ONCHIP_P = PHYS_W'(ONCHIP_BYTES);

  wire acc = req_valid_i && req_ready_o;

  assert_onchip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o && !rsp_ext_o |-> (rsp_addr_o - PHYS_W'(SRAM_BASE)) < ONCHIP_P);

  assert_ext_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ext_o |-> !rsp_err_o);

  assert_err_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> (rsp_addr_o == '0) && !rsp_ext_o);

  assert_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (req_addr_i >= TOP_L) |=> rsp_valid_o && rsp_err_o);

  assert_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (req_size_i == 2'd2) && (req_addr_i[1:0] != 2'b00) |=> rsp_err_o);

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  assert_stall_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=>
      rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_ext_o) && $stable(rsp_err_o));

  assert_flow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_i |-> req_ready_o);
endmodule

bind fb_xlate fb_xlate_chk #(
  .LIN_W(LIN_W), .PHYS_W(fb_xlate_pkg::PHYS_W), .ONCHIP_BYTES(ONCHIP_BYTES),
  .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES), .SRAM_BASE(SRAM_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_addr_o(rsp_addr_o), .rsp_ext_o(rsp_ext_o), .rsp_err_o(rsp_err_o)
);

// File: tb/sim_fb_xlate.sv
module sim_fb_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [31:0] rsp_addr_o;
  logic        rsp_ext_o;
  logic        rsp_err_o;
  logic        pt_we_i = 1'b0;
  logic [4:0]  pt_idx_i = '0;
  logic [19:0] pt_base_i = '0;
  logic        pt_valid_i = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  fb_xlate u0 (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] exp_addr;
    logic        exp_ext;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 2'd2, 32'hB000_0000, 1'b0, 1'b0, 4'd1},  // R1 base
    '{32'h0001_3FFF, 2'd0, 32'hB001_3FFF, 1'b0, 1'b0, 4'd1},  // R1 last on-chip byte
    '{32'h0001_4000, 2'd2, 32'h8000_0000, 1'b1, 1'b0, 4'd2},  // R2 first overflow
    '{32'h0001_4FFE, 2'd1, 32'h8000_0FFE, 1'b1, 1'b0, 4'd2},  // R2
    '{32'h0001_5004, 2'd2, 32'h8012_3004, 1'b1, 1'b0, 4'd2},  // R2 page 1
    '{32'h0001_6000, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 4'd3},  // R3 invalid page 2
    '{32'h0001_9ABC, 2'd1, 32'hABCD_EABC, 1'b1, 1'b0, 4'd2},  // R2 page 5
    '{32'h0003_3FFF, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd2},  // R2 page 31
    '{32'h0003_4000, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 4'd4},  // R4 past table
    '{32'h0000_0002, 2'd2, 32'h0000_0000, 1'b0, 1'b1, 4'd5},  // R5 word misaligned
    '{32'h0001_4001, 2'd1, 32'h0000_0000, 1'b0, 1'b1, 4'd5},  // R5 half misaligned
    '{32'h0001_4000, 2'd3, 32'h0000_0000, 1'b0, 1'b1, 4'd5},  // R5 reserved size
    '{32'h0000_1001, 2'd1, 32'h0000_0000, 1'b0, 1'b1, 4'd5}   // R5 on-chip misaligned
  };

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input logic [31:0] a, input logic e, input logic r);
    check(tag, {1'b1, rsp_valid_o, rsp_addr_o, rsp_ext_o, rsp_err_o}, {1'b1, 1'b1, a, e, r});
  endtask

  task automatic pt_write(input logic [4:0] idx, input logic [19:0] base, input logic v);
    pt_we_i = 1'b1; pt_idx_i = idx; pt_base_i = base; pt_valid_i = v;
    @(negedge clk_i);
    pt_we_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog R6: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 reset", {33'b0, rsp_valid_o, req_ready_o}, {33'b0, 1'b0, 1'b1});
    // R9 table empty after reset
    req_valid_i = 1'b1; req_addr_i = 32'h0001_4000; req_size_i = 2'd2;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_rsp("R9 empty table", 32'h0, 1'b0, 1'b1);
    @(negedge clk_i);

    pt_write(5'd0, 20'h80000, 1'b1);
    pt_write(5'd1, 20'h80123, 1'b1);
    pt_write(5'd5, 20'hABCDE, 1'b1);
    pt_write(5'd31, 20'hFFFFF, 1'b1);

    // vector walk, back-to-back (R10)
    rsp_ready_i = 1'b1;
    for (int i = 0; i <= NV; i++) begin
      if (i > 0)
        chk_rsp($sformatf("R%0d vec%0d", VECS[i-1].req, i-1),
                VECS[i-1].exp_addr, VECS[i-1].exp_ext, VECS[i-1].exp_err);
      if (i < NV) begin
        req_valid_i = 1'b1; req_addr_i = VECS[i].addr; req_size_i = VECS[i].size;
        check("R10 ready", {34'b0, req_ready_o}, {34'b0, 1'b1});
      end else begin
        req_valid_i = 1'b0;
      end
      @(negedge clk_i);
    end

    // R8 same-cycle write and lookup of entry 3
    pt_we_i = 1'b1; pt_idx_i = 5'd3; pt_base_i = 20'h12345; pt_valid_i = 1'b1;
    req_valid_i = 1'b1; req_addr_i = 32'h0001_7000; req_size_i = 2'd2;
    @(negedge clk_i);
    pt_we_i = 1'b0;
    chk_rsp("R8 old entry", 32'h0, 1'b0, 1'b1);
    req_addr_i = 32'h0001_7010;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_rsp("R8 new entry", 32'h1234_5010, 1'b1, 1'b0);
    @(negedge clk_i);

    // R3 invalidate entry 0
    pt_write(5'd0, 20'h0, 1'b0);
    req_valid_i = 1'b1; req_addr_i = 32'h0001_4004; req_size_i = 2'd2;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_rsp("R3 invalidated", 32'h0, 1'b0, 1'b1);
    @(negedge clk_i);

    // R7 backpressure
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b1; req_addr_i = 32'h0000_0100; req_size_i = 2'd2;
    @(negedge clk_i);
    req_addr_i = 32'h0001_5008;
    chk_rsp("R7 first", 32'hB000_0100, 1'b0, 1'b0);
    check("R7 ready low", {34'b0, req_ready_o}, {34'b0, 1'b0});
    @(negedge clk_i);
    chk_rsp("R7 held", 32'hB000_0100, 1'b0, 1'b0);
    check("R7 ready still low", {34'b0, req_ready_o}, {34'b0, 1'b0});
    rsp_ready_i = 1'b1;
    #1;
    check("R7 ready on release", {34'b0, req_ready_o}, {34'b0, 1'b1});
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_rsp("R7 pending taken", 32'h8012_3008, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R6 drained", {34'b0, rsp_valid_o}, {34'b0, 1'b0});

    finish_run();
  end
endmodule